// File: doc/BRIEF.md
# Channel Sync Acquisition and Loss Monitor

This block keeps track of whether one serial receive lane is word-synchronised. One copy sits beside each lane's decoder. Each cycle it looks at the lane's byte strobe, the decoder's error flag and its comma flag. It also watches two slower signals: the clock-recovery lock indication and a software-controlled enable for channel locking. From these it produces a sync flag and a loss-of-sync status.

The controller has three states. `ST_NOSYNC` waits until the clock-recovery lock has been qualified. `ST_ARMED` hunts for four back-to-back comma bytes. `ST_SYNC` is the locked state. The transitions are named as follows:

- **ARM** goes from `ST_NOSYNC` to `ST_ARMED` once clock lock is qualified and locking is enabled.
- **LOCK** goes from `ST_ARMED` to `ST_SYNC` when the comma run completes.
- **DROP** returns to `ST_NOSYNC` from any state. It fires when clock lock falls or the enable falls. It also fires from `ST_SYNC` when either error criterion trips.

Reset forces `ST_NOSYNC` directly. Qualification requires the lock input to stay high for a parameterised number of consecutive cycles. The default is 32000, and any low cycle restarts the count. Error monitoring runs only while in `ST_SYNC`. It uses two criteria at once: a run of consecutive errored bytes, and an error count inside fixed, non-overlapping 16-byte blocks.

Top module: `chan_sync_monitor`

## Requirements
- R1: While `rst_n` is low the state is `ST_NOSYNC` and `in_sync` is 0. This takes effect without waiting for a clock edge.
- R2: ARM is allowed only after `cdr_lock` has been sampled high on QUAL_CYCLES consecutive edges, and a single low sample restarts the count. With `lock_en` high and valid comma bytes present from the first high sample, `in_sync` is 0 after edge QUAL_CYCLES+4 and 1 after edge QUAL_CYCLES+5.
- R3: A low `cdr_lock` or a low `lock_en` sampled at an edge leaves the block out of sync after that edge, whatever the state.
- R4: In `ST_SYNC`, the edge that samples the fourth consecutive valid byte with `dec_err`=1 performs DROP. Bytes with `byte_vld`=0 neither extend nor break the run.
- R5: In `ST_SYNC`, the edge that samples the ninth errored byte of a 16-byte block performs DROP. A block counts only valid bytes, starts when `ST_SYNC` is entered, and restarts after every 16th valid byte.
- R6: In `ST_ARMED`, LOCK happens on the edge that samples the fourth consecutive valid byte with `comma`=1. A valid byte with `comma`=0 restarts the run, and bytes with `byte_vld`=0 are ignored.
- R7: `in_sync` is 1 exactly in `ST_SYNC`. `los` is 1 exactly when `lock_en` is 1 and the state is not `ST_SYNC`.
- R8: When a loss condition and the completing comma arrive at the same edge, the loss wins and the state does not reach `ST_SYNC`.
- R9: After any DROP, reaching `ST_SYNC` again needs a complete comma run. If `cdr_lock` fell, it also needs a fresh qualification period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous device reset |
| cdr_lock | input | 1 | Clock-recovery lock indication |
| lock_en | input | 1 | Channel-lock enable |
| byte_vld | input | 1 | One received byte is presented this cycle |
| dec_err | input | 1 | The presented byte had a decode error |
| comma | input | 1 | The presented byte is the sync comma character |
| in_sync | output | 1 | Lane is in the Sync state |
| los | output | 1 | Loss-of-sync status, valid while locking is enabled |

## Verification
Two groups of events can land on the same edge. The first group is a loss condition and the comma that completes acquisition. The bench provokes this by dropping `lock_en` on the fourth comma and requires that the block stays out of sync with `los` low. The second group is the two error criteria themselves. The vector table places an error that would be the ninth of a block right after a block boundary. It then builds a four-byte run around an idle byte. The table also isolates each criterion, so that only the intended one can explain each drop.

// File: rtl/chsync_pkg.sv
package chsync_pkg;

    typedef enum logic [1:0] {
        ST_NOSYNC = 2'd0,
        ST_ARMED  = 2'd1,
        ST_SYNC   = 2'd2
    } sync_state_e;

endpackage

// File: rtl/chsync_lock_qual.sv
module chsync_lock_qual #(
    parameter int QUAL_CYCLES = 32000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cdr_lock,
    output logic qualified
);

    generate
        if (QUAL_CYCLES == 0) begin : g_bypass
            assign qualified = cdr_lock;
        end else begin : g_count
            localparam int QW = $clog2(QUAL_CYCLES + 1);
            localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

            logic [QW-1:0] qcnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    qcnt <= '0;
                end else if (!cdr_lock) begin
                    qcnt <= '0;
                end else if (qcnt != QMAX) begin
                    qcnt <= qcnt + 1'b1;
                end
            end

            assign qualified = (qcnt == QMAX);
        end
    endgenerate

endmodule

// File: rtl/chsync_err_mon.sv
module chsync_err_mon #(
    parameter int ERR_RUN   = 4,
    parameter int WIN_LEN   = 16,
    parameter int WIN_LIMIT = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic byte_vld,
    input  logic dec_err,
    output logic run_trip,
    output logic dens_trip
);

    localparam int RW = (ERR_RUN > 1) ? $clog2(ERR_RUN) : 1;
    localparam int PW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int EW = $clog2(WIN_LEN + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(ERR_RUN - 1);
    localparam logic [PW-1:0] POS_LAST = PW'(WIN_LEN - 1);
    localparam logic [EW-1:0] ERR_LAST = EW'(WIN_LIMIT - 1);

    logic [RW-1:0] run_cnt;
    logic [PW-1:0] pos;
    logic [EW-1:0] ecnt;
    logic          bad;

    assign bad = byte_vld && dec_err;

    // consecutive errored valid bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clear) begin
            run_cnt <= '0;
        end else if (byte_vld) begin
            if (!dec_err) begin
                run_cnt <= '0;
            end else if (run_cnt != RUN_LAST) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // fixed, non-overlapping block of valid bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos  <= '0;
            ecnt <= '0;
        end else if (clear) begin
            pos  <= '0;
            ecnt <= '0;
        end else if (byte_vld) begin
            if (pos == POS_LAST) begin
                pos  <= '0;
                ecnt <= '0;
            end else begin
                pos  <= pos + 1'b1;
                ecnt <= ecnt + EW'(dec_err);
            end
        end
    end

    assign run_trip  = bad && (run_cnt == RUN_LAST);
    assign dens_trip = bad && (ecnt == ERR_LAST);

endmodule

// File: rtl/chsync_comma_run.sv
module chsync_comma_run #(
    parameter int COMMA_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic byte_vld,
    input  logic comma,
    output logic done
);

    localparam int CW = (COMMA_RUN > 1) ? $clog2(COMMA_RUN) : 1;
    localparam logic [CW-1:0] CLAST = CW'(COMMA_RUN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (byte_vld) begin
            if (!comma) begin
                cnt <= '0;
            end else if (cnt != CLAST) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done = byte_vld && comma && (cnt == CLAST);

endmodule

// File: rtl/chan_sync_monitor.sv
module chan_sync_monitor
    import chsync_pkg::*;
#(
    parameter int QUAL_CYCLES = 32000,
    parameter int COMMA_RUN   = 4,
    parameter int ERR_RUN     = 4,
    parameter int WIN_LEN     = 16,
    parameter int WIN_LIMIT   = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cdr_lock,
    input  logic lock_en,
    input  logic byte_vld,
    input  logic dec_err,
    input  logic comma,
    output logic in_sync,
    output logic los
);

    sync_state_e state;
    sync_state_e nxt;
    logic        qualified;
    logic        comma_done;
    logic        run_trip;
    logic        dens_trip;

    chsync_lock_qual #(
        .QUAL_CYCLES (QUAL_CYCLES)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .cdr_lock  (cdr_lock),
        .qualified (qualified)
    );

    chsync_comma_run #(
        .COMMA_RUN (COMMA_RUN)
    ) u_comma (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state != ST_ARMED),
        .byte_vld (byte_vld),
        .comma    (comma),
        .done     (comma_done)
    );

    chsync_err_mon #(
        .ERR_RUN   (ERR_RUN),
        .WIN_LEN   (WIN_LEN),
        .WIN_LIMIT (WIN_LIMIT)
    ) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state != ST_SYNC),
        .byte_vld  (byte_vld),
        .dec_err   (dec_err),
        .run_trip  (run_trip),
        .dens_trip (dens_trip)
    );

    // next-state: DROP on a lost lock or enable outranks ARM and LOCK
    always_comb begin
        nxt = state;
        if (!cdr_lock || !lock_en) begin
            nxt = ST_NOSYNC;
        end else begin
            unique case (state)
                ST_NOSYNC: if (qualified)              nxt = ST_ARMED;
                ST_ARMED:  if (comma_done)             nxt = ST_SYNC;
                ST_SYNC:   if (run_trip || dens_trip)  nxt = ST_NOSYNC;
                default:                               nxt = ST_NOSYNC;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_NOSYNC;
        end else begin
            state <= nxt;
        end
    end

    // outputs
    always_comb begin
        in_sync = (state == ST_SYNC);
        los     = lock_en && (state != ST_SYNC);
    end

endmodule

// File: rtl/chan_sync_monitor_chk.sv
module chan_sync_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic cdr_lock,
    input logic lock_en,
    input logic byte_vld,
    input logic comma,
    input logic in_sync,
    input logic qualified,
    input logic run_trip,
    input logic dens_trip
);

    AST_UNLOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !cdr_lock |=> !in_sync); // R3

    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_en |=> !in_sync); // R3

    AST_RUN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && run_trip) |=> !in_sync); // R4

    AST_DENSITY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && dens_trip) |=> !in_sync); // R5

    AST_SYNC_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(qualified)); // R2

    AST_SYNC_NEEDS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(byte_vld && comma && lock_en)); // R6

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_NOSYNC: assert (!in_sync); // R1
        end
    end

endmodule

bind chan_sync_monitor chan_sync_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cdr_lock  (cdr_lock),
    .lock_en   (lock_en),
    .byte_vld  (byte_vld),
    .comma     (comma),
    .in_sync   (in_sync),
    .qualified (qualified),
    .run_trip  (run_trip),
    .dens_trip (dens_trip)
);

// File: tb/tb_chan_sync_monitor.sv
`timescale 1ns/1ps
module tb_chan_sync_monitor;

    localparam int QUAL = 6;
    localparam int NVEC = 40;

    // vector bits: {byte_vld, dec_err, comma, expected in_sync}; lock and enable held high
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1101, 4'b1101, 4'b1101, 4'b1001, 4'b0101,
        4'b1101, 4'b1101, 4'b1101, 4'b1001, 4'b1101,
        4'b1001, 4'b1101, 4'b1001, 4'b1100, 4'b0000,
        4'b1010, 4'b1010, 4'b1010, 4'b1011,
        4'b1101, 4'b1001, 4'b1101, 4'b1001, 4'b1101, 4'b1001, 4'b1101, 4'b1001,
        4'b1101, 4'b1001, 4'b1101, 4'b1001, 4'b1101, 4'b1001, 4'b1101, 4'b1001,
        4'b1101, 4'b1101, 4'b0001, 4'b1101, 4'b1100
    };

    logic clk = 1'b0;
    logic rst_n, cdr_lock, lock_en, byte_vld, dec_err, comma;
    logic in_sync, los;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    chan_sync_monitor #(.QUAL_CYCLES(QUAL)) dut (
        .clk(clk), .rst_n(rst_n), .cdr_lock(cdr_lock), .lock_en(lock_en),
        .byte_vld(byte_vld), .dec_err(dec_err), .comma(comma),
        .in_sync(in_sync), .los(los)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic e, input logic c);
        byte_vld = v; dec_err = e; comma = c;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cdr_lock = 1'b0; lock_en = 1'b1; drive(0, 0, 0);
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // reset, qualify with commas streaming, arrive in sync after QUAL+5 edges
    task automatic go_sync();
        do_reset();
        cdr_lock = 1'b1; drive(1, 0, 1);
        for (int i = 0; i < QUAL + 5; i++) tick();
        drive(0, 0, 0);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 / R7: reset state, los follows the enable
        rst_n = 1'b0; cdr_lock = 1'b0; lock_en = 1'b1; drive(0, 0, 0);
        tick();
        check("R1", "in_sync in reset", in_sync, 1'b0);
        check("R7", "los in reset with enable", los, 1'b1);
        lock_en = 1'b0; #1;
        check("R7", "los with enable low", los, 1'b0);

        // R2: exact qualification timing
        do_reset();
        cdr_lock = 1'b1; drive(1, 0, 1);
        for (int i = 0; i < QUAL + 4; i++) tick();
        check("R2", "in_sync one edge early", in_sync, 1'b0);
        tick();
        check("R2", "in_sync on time", in_sync, 1'b1);
        check("R7", "los in sync", los, 1'b0);

        // R2: one low sample restarts qualification
        do_reset();
        cdr_lock = 1'b1; drive(1, 0, 1);
        for (int i = 0; i < QUAL - 1; i++) tick();
        cdr_lock = 1'b0; tick();
        cdr_lock = 1'b1;
        for (int i = 0; i < QUAL + 4; i++) tick();
        check("R2", "restart, early", in_sync, 1'b0);
        tick();
        check("R2", "restart, on time", in_sync, 1'b1);

        // R4 / R5 / R6 / R9: vector table starting in sync
        go_sync();
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][3], VEC[i][2], VEC[i][1]);
            tick();
            check("R4/R5/R6/R9", $sformatf("vector %0d in_sync", i), in_sync, VEC[i][0]);
            check("R7", $sformatf("vector %0d los", i), los, ~VEC[i][0]);
        end

        // R3 enable drop, then R9 re-acquire without re-qualifying
        go_sync();
        lock_en = 1'b0; tick();
        check("R3", "enable drop", in_sync, 1'b0);
        check("R7", "los after enable drop", los, 1'b0);
        lock_en = 1'b1; drive(1, 0, 1);
        for (int i = 0; i < 4; i++) tick();
        check("R9", "re-acquire early", in_sync, 1'b0);
        tick();
        check("R9", "re-acquire done", in_sync, 1'b1);

        // R3 clock-lock drop, then R9 needs full qualification again
        cdr_lock = 1'b0; drive(0, 0, 0); tick();
        check("R3", "lock drop", in_sync, 1'b0);
        check("R7", "los after lock drop", los, 1'b1);
        cdr_lock = 1'b1; drive(1, 0, 1);
        for (int i = 0; i < QUAL + 4; i++) tick();
        check("R9", "relock early", in_sync, 1'b0);
        tick();
        check("R9", "relock done", in_sync, 1'b1);

        // R6: broken comma run, ignored idle byte
        do_reset();
        cdr_lock = 1'b1; drive(0, 0, 0);
        for (int i = 0; i < QUAL + 1; i++) tick();
        drive(1, 0, 1); tick(); tick(); tick();
        drive(1, 0, 0); tick();
        drive(1, 0, 1); tick(); tick(); tick();
        check("R6", "run broken by non-comma", in_sync, 1'b0);
        drive(0, 0, 1); tick();
        check("R6", "idle byte ignored", in_sync, 1'b0);
        drive(1, 0, 1); tick();
        check("R6", "run completes", in_sync, 1'b1);

        // R8: fourth comma coincides with enable drop
        do_reset();
        cdr_lock = 1'b1; drive(0, 0, 0);
        for (int i = 0; i < QUAL + 1; i++) tick();
        drive(1, 0, 1); tick(); tick(); tick();
        lock_en = 1'b0; tick();
        check("R8", "loss beats lock", in_sync, 1'b0);
        check("R8", "los with enable low", los, 1'b0);

        // R1: asynchronous reset while in sync
        go_sync();
        rst_n = 1'b0; #1;
        check("R1", "async reset", in_sync, 1'b0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule